// File: doc/BRIEF.md
# GF(16) Reed-Solomon Encoder and Syndrome Generator

This block protects short control messages on a noisy serial link. It uses a shortened Reed-Solomon code over 4-bit symbols. The transmit half takes a 10-symbol (40-bit) message one symbol per clock and passes each symbol straight through. It then appends four check symbols, which are the remainder of x^4·m(x) divided by the generator polynomial. The generator is g(x) = (x+1)(x+α)(x+α²)(x+α³). The field is built from the primitive polynomial x^4 + x + 1, with α = 2.

The receive half takes a 14-symbol codeword, also one symbol per clock. It evaluates the received polynomial at the four generator roots using Horner's rule. Each multiplication is by a fixed constant and is done through a precomputed 16-entry table. The cell for root α^0 = 1 needs no table and is a plain XOR accumulator. The four syndromes are presented together with a flag that tells whether all four are zero. A later stage that locates and corrects errors consumes these outputs. Both halves count symbols themselves, so an idle cycle simply does not advance them.

Top module: `rs16_codec`

## Requirements
- R1: After reset, `enc_ready` is 1, and `enc_out_valid`, `enc_out_par` and `syn_done` are 0.
- R2: Each message symbol accepted (`enc_valid` and `enc_ready` both 1) appears on `enc_out_sym` in the next cycle, with `enc_out_valid`=1 and `enc_out_par`=0.
- R3: The 10th accepted symbol drops `enc_ready` for exactly 4 cycles. From the second cycle after that symbol, four consecutive outputs carry `enc_out_par`=1 and the check symbols, highest degree first. The check symbols are the coefficients of x^4·m(x) mod g(x), where the first message symbol is the coefficient of x^13.
- R4: `enc_valid` and `enc_sym` are ignored while `enc_ready` is 0. The check symbols and the next codeword are unaffected by them.
- R5: A complete encoder output of 14 symbols is a valid codeword. Fed to the receive half, it gives all four syndromes zero and `syn_zero`=1.
- R6: Symbol i of a received word (i = 0..13, first symbol i = 0) is the coefficient of x^(13-i). Syndrome S_j = Σ r_i·α^(j·(13-i)) for j = 0..3 is placed on `syn_vec[4j+3:4j]`.
- R7: `syn_done` pulses for one cycle, in the cycle after the 14th accepted received symbol. In that same cycle, `syn_zero` is 1 exactly when all four syndromes are zero.
- R8: A cycle with `syn_valid`=0 does not advance the syndrome unit, whatever `syn_sym` holds.
- R9: A cycle with `enc_valid`=0 while `enc_ready`=1 does not advance the encoder, and gives `enc_out_valid`=0 in the next cycle.
- R10: `syn_vec` and `syn_zero` keep their values until the next word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid | input | 1 | Message symbol present |
| enc_sym | input | 4 | Message symbol |
| enc_ready | output | 1 | Encoder accepts message symbols |
| enc_out_valid | output | 1 | Codeword symbol present on `enc_out_sym` |
| enc_out_sym | output | 4 | Codeword symbol |
| enc_out_par | output | 1 | Current output symbol is a check symbol |
| syn_valid | input | 1 | Received symbol present |
| syn_sym | input | 4 | Received symbol |
| syn_done | output | 1 | Syndromes of a finished word are available |
| syn_vec | output | 16 | Syndromes, S_j in bits [4j+3:4j] |
| syn_zero | output | 1 | All four syndromes are zero |

## Verification
The encoder is driven with:
- every message that has a single nonzero symbol, which shows that each generator coefficient and each table entry are correct on their own;
- a family of ramp messages, which mixes the contributions of many symbols.

Each encoder output is sent back through the syndrome unit. A zero syndrome there confirms the codeword independently of the bench's long division.

The syndrome unit is swept with every single-symbol error value at every position. This separates the four root tables and the Horner order, since each (position, value) pair produces a distinct syndrome set.

Runs with idle gaps and with junk symbols driven during the check-symbol phase confirm that only accepted symbols change state.

// File: rtl/rs16_pkg.sv
package rs16_pkg;

  localparam int SYM_W = 4;

  // Multiply in GF(16), reducing by x^4 + x + 1.
  function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc;
    logic [3:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic logic [3:0] gf_pow(input int e);
    logic [3:0] r;
    r = 4'h1;
    for (int i = 0; i < e; i++) r = gf_mul(r, 4'h2);
    return r;
  endfunction

  // Generator polynomial with roots alpha^0 .. alpha^(npar-1).
  // Coefficient of x^i is held in bits [4i+3:4i].
  function automatic logic [63:0] gen_poly(input int npar);
    logic [63:0] g;
    logic [3:0]  root;
    g = '0;
    g[3:0] = 4'h1;
    for (int r = 0; r < npar; r++) begin
      root = gf_pow(r);
      for (int i = 15; i >= 1; i--)
        g[i*4 +: 4] = g[(i-1)*4 +: 4] ^ gf_mul(root, g[i*4 +: 4]);
      g[3:0] = gf_mul(root, g[3:0]);
    end
    return g;
  endfunction

  // 16-entry lookup table for multiplication by the constant k.
  function automatic logic [63:0] const_tbl(input logic [3:0] k);
    logic [63:0] t;
    for (int v = 0; v < 16; v++) t[v*4 +: 4] = gf_mul(4'(v), k);
    return t;
  endfunction

endpackage

// File: rtl/rs16_lfsr_enc.sv
module rs16_lfsr_enc import rs16_pkg::*; #(
  parameter int NDATA = 10,
  parameter int NPAR  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_sym,
  output logic             ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_par
);
  localparam int CNT_MAX = (NDATA > NPAR) ? NDATA : NPAR;
  localparam int CW      = $clog2(CNT_MAX) + 1;
  localparam int RW      = NPAR * SYM_W;
  localparam logic [63:0] GP = gen_poly(NPAR);

  logic [RW-1:0]    rem_q;
  logic [RW-1:0]    rem_feed;
  logic [RW-1:0]    rem_shift;
  logic [RW-1:0]    prod;
  logic [CW-1:0]    cnt_q;
  logic             par_phase_q;
  logic [SYM_W-1:0] top_sym;
  logic [SYM_W-1:0] fb;
  logic             take;
  logic             last_data;
  logic             last_par;

  assign top_sym   = rem_q[RW-1 -: SYM_W];
  assign fb        = in_sym ^ top_sym;
  assign ready     = ~par_phase_q;
  assign take      = in_valid & ready;
  assign last_data = (cnt_q == CW'(NDATA - 1));
  assign last_par  = (cnt_q == CW'(NPAR - 1));

  // One constant-multiplier table per generator coefficient.
  for (genvar k = 0; k < NPAR; k++) begin : g_tap
    localparam logic [63:0] TBL = const_tbl(GP[k*4 +: 4]);
    assign prod[k*SYM_W +: SYM_W] = TBL[{fb, 2'b00} +: 4];
    if (k == 0) begin : g_low
      assign rem_feed[SYM_W-1:0]  = prod[SYM_W-1:0];
      assign rem_shift[SYM_W-1:0] = '0;
    end else begin : g_up
      assign rem_feed[k*SYM_W +: SYM_W]  = rem_q[(k-1)*SYM_W +: SYM_W] ^ prod[k*SYM_W +: SYM_W];
      assign rem_shift[k*SYM_W +: SYM_W] = rem_q[(k-1)*SYM_W +: SYM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q       <= '0;
      cnt_q       <= '0;
      par_phase_q <= 1'b0;
      out_valid   <= 1'b0;
      out_sym     <= '0;
      out_par     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_par   <= 1'b0;
      if (!par_phase_q) begin
        if (take) begin
          out_valid <= 1'b1;
          out_sym   <= in_sym;
          rem_q     <= rem_feed;
          if (last_data) begin
            cnt_q       <= '0;
            par_phase_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else begin
        out_valid <= 1'b1;
        out_par   <= 1'b1;
        out_sym   <= top_sym;
        rem_q     <= rem_shift;
        if (last_par) begin
          cnt_q       <= '0;
          par_phase_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rs16_syn_cell.sv
module rs16_syn_cell import rs16_pkg::*; #(
  parameter int ROOT_EXP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first,
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] acc_next
);
  logic [SYM_W-1:0] acc_q;
  logic [SYM_W-1:0] scaled;

  if (ROOT_EXP == 0) begin : g_unity
    assign scaled = acc_q;
  end else begin : g_table
    localparam logic [63:0] TBL = const_tbl(gf_pow(ROOT_EXP));
    assign scaled = TBL[{acc_q, 2'b00} +: 4];
  end

  // Horner step: previous sum times root, plus the incoming symbol.
  assign acc_next = (first ? '0 : scaled) ^ sym;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_next;
  end
endmodule

// File: rtl/rs16_syndrome.sv
module rs16_syndrome import rs16_pkg::*; #(
  parameter int NCODE = 14,
  parameter int NPAR  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [SYM_W-1:0]      in_sym,
  output logic                  done,
  output logic [NPAR*SYM_W-1:0] syn,
  output logic                  all_zero
);
  localparam int CW = $clog2(NCODE) + 1;

  logic [CW-1:0]           cnt_q;
  logic                    first;
  logic                    last;
  logic [NPAR*SYM_W-1:0]   nxt;

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == CW'(NCODE - 1));

  for (genvar j = 0; j < NPAR; j++) begin : g_cell
    rs16_syn_cell #(.ROOT_EXP(j)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (in_valid),
      .first    (first),
      .sym      (in_sym),
      .acc_next (nxt[j*SYM_W +: SYM_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      done     <= 1'b0;
      syn      <= '0;
      all_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        if (last) begin
          cnt_q    <= '0;
          done     <= 1'b1;
          syn      <= nxt;
          all_zero <= (nxt == '0);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rs16_codec.sv
module rs16_codec import rs16_pkg::*; #(
  parameter int NDATA = 10,
  parameter int NPAR  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enc_valid,
  input  logic [SYM_W-1:0]      enc_sym,
  output logic                  enc_ready,
  output logic                  enc_out_valid,
  output logic [SYM_W-1:0]      enc_out_sym,
  output logic                  enc_out_par,
  input  logic                  syn_valid,
  input  logic [SYM_W-1:0]      syn_sym,
  output logic                  syn_done,
  output logic [NPAR*SYM_W-1:0] syn_vec,
  output logic                  syn_zero
);
  localparam int NCODE = NDATA + NPAR;

  rs16_lfsr_enc #(.NDATA(NDATA), .NPAR(NPAR)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_valid),
    .in_sym    (enc_sym),
    .ready     (enc_ready),
    .out_valid (enc_out_valid),
    .out_sym   (enc_out_sym),
    .out_par   (enc_out_par)
  );

  rs16_syndrome #(.NCODE(NCODE), .NPAR(NPAR)) u_syn (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (syn_valid),
    .in_sym   (syn_sym),
    .done     (syn_done),
    .syn      (syn_vec),
    .all_zero (syn_zero)
  );
endmodule

// File: rtl/rs16_codec_chk.sv
module rs16_codec_chk #(
  parameter int NDATA = 10,
  parameter int NPAR  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enc_valid,
  input logic [3:0]          enc_sym,
  input logic                enc_ready,
  input logic                enc_out_valid,
  input logic [3:0]          enc_out_sym,
  input logic                enc_out_par,
  input logic                syn_done,
  input logic [NPAR*4-1:0]   syn_vec,
  input logic                syn_zero
);
  logic [7:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         low_run <= '0;
    else if (enc_ready) low_run <= '0;
    else                low_run <= low_run + 1'b1;
  end

  // R2: accepted symbol passes through one cycle later
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && enc_ready) |=> (enc_out_valid && !enc_out_par && enc_out_sym == $past(enc_sym)));

  // R9: idle cycle gives no output
  a_r9_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_ready && !enc_valid) |=> !enc_out_valid);

  // R3: check symbols follow every stall cycle
  a_r3_par_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_ready |=> (enc_out_valid && enc_out_par));

  // R3: stall window no longer than the parity count
  a_r3_stall_window: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_ready |-> (low_run < 8'(NPAR)));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    syn_done |=> !syn_done);

  // R7: zero flag agrees with the syndrome vector
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    syn_done |-> (syn_zero == (syn_vec == '0)));

  // R10: results held between completions
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_done |-> ($stable(syn_vec) && $stable(syn_zero)));
endmodule

bind rs16_codec rs16_codec_chk #(.NDATA(NDATA), .NPAR(NPAR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enc_valid     (enc_valid),
  .enc_sym       (enc_sym),
  .enc_ready     (enc_ready),
  .enc_out_valid (enc_out_valid),
  .enc_out_sym   (enc_out_sym),
  .enc_out_par   (enc_out_par),
  .syn_done      (syn_done),
  .syn_vec       (syn_vec),
  .syn_zero      (syn_zero)
);

// File: tb/tb_rs16_codec.sv
module tb_rs16_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_valid = 1'b0;
  logic [3:0]  enc_sym = '0;
  logic        enc_ready;
  logic        enc_out_valid;
  logic [3:0]  enc_out_sym;
  logic        enc_out_par;
  logic        syn_valid = 1'b0;
  logic [3:0]  syn_sym = '0;
  logic        syn_done;
  logic [15:0] syn_vec;
  logic        syn_zero;

  int checks = 0;
  int errors = 0;

  logic [3:0] ex [0:14];
  logic [3:0] lg [0:15];
  logic [3:0] gpoly [0:4];
  logic [3:0] msg [0:9];
  logic [3:0] cw_ref [0:13];
  logic [3:0] cw_dut [0:13];
  logic [3:0] rx [0:13];

  always #2.5 clk = ~clk;

  rs16_codec dut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .enc_sym(enc_sym), .enc_ready(enc_ready),
    .enc_out_valid(enc_out_valid), .enc_out_sym(enc_out_sym), .enc_out_par(enc_out_par),
    .syn_valid(syn_valid), .syn_sym(syn_sym),
    .syn_done(syn_done), .syn_vec(syn_vec), .syn_zero(syn_zero)
  );

  function automatic logic [3:0] bmul(input logic [3:0] a, input logic [3:0] b);
    if (a == 0 || b == 0) return 4'h0;
    return ex[(int'(lg[a]) + int'(lg[b])) % 15];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Remainder of x^4*m(x) by long division, first symbol highest degree.
  task automatic ref_encode();
    logic [3:0] w [0:13];
    for (int i = 0; i < 14; i++) w[i] = (i < 10) ? msg[i] : 4'h0;
    for (int i = 0; i < 10; i++) begin
      logic [3:0] q;
      q = w[i];
      for (int j = 1; j <= 4; j++) w[i+j] = w[i+j] ^ bmul(q, gpoly[j]);
    end
    for (int i = 0; i < 14; i++) cw_ref[i] = (i < 10) ? msg[i] : w[i];
  endtask

  function automatic logic [3:0] ref_syn(input int j);
    logic [3:0] s;
    s = 4'h0;
    for (int i = 0; i < 14; i++) s = s ^ bmul(rx[i], ex[(j * (13 - i)) % 15]);
    return s;
  endfunction

  task automatic run_enc(input int gap, input bit junk);
    ref_encode();
    for (int i = 0; i < 10; i++) begin
      for (int g = 0; g < gap; g++) begin
        enc_valid = 1'b0; enc_sym = 4'hA;
        @(posedge clk); @(negedge clk);
        check(!enc_out_valid, "R9 idle", int'(enc_out_valid), 0);
      end
      enc_valid = 1'b1; enc_sym = msg[i];
      @(posedge clk); @(negedge clk);
      check(enc_out_valid && !enc_out_par && enc_out_sym == msg[i], "R2 passthrough",
            int'(enc_out_sym), int'(msg[i]));
      cw_dut[i] = enc_out_sym;
    end
    check(!enc_ready, "R3 ready low", int'(enc_ready), 0);
    enc_valid = junk; enc_sym = 4'hF;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      check(enc_out_valid && enc_out_par && enc_out_sym == cw_ref[10+k], "R3 R4 parity",
            int'(enc_out_sym), int'(cw_ref[10+k]));
      cw_dut[10+k] = enc_out_sym;
      if (k < 3) check(!enc_ready, "R3 stall", int'(enc_ready), 0);
    end
    check(enc_ready, "R3 ready back", int'(enc_ready), 1);
    enc_valid = 1'b0;
  endtask

  task automatic run_syn(input int gap);
    logic [15:0] exp_v;
    for (int j = 0; j < 4; j++) exp_v[j*4 +: 4] = ref_syn(j);
    for (int i = 0; i < 14; i++) begin
      for (int g = 0; g < gap; g++) begin
        syn_valid = 1'b0; syn_sym = 4'(i + 5);
        @(posedge clk); @(negedge clk);
        check(!syn_done, "R8 gap", int'(syn_done), 0);
      end
      syn_valid = 1'b1; syn_sym = rx[i];
      @(posedge clk); @(negedge clk);
    end
    syn_valid = 1'b0;
    check(syn_done, "R7 done", int'(syn_done), 1);
    check(syn_vec == exp_v, "R6 syndromes", int'(syn_vec), int'(exp_v));
    check(syn_zero == (exp_v == 0), "R7 zero flag", int'(syn_zero), int'(exp_v == 0));
    @(posedge clk); @(negedge clk);
    check(!syn_done && syn_vec == exp_v, "R10 hold", int'(syn_vec), int'(exp_v));
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] v;
    logic [3:0] gl [0:4];
    v = 5'h1;
    for (int i = 0; i < 15; i++) begin
      ex[i] = v[3:0]; lg[v[3:0]] = 4'(i);
      v = {v[3:0], 1'b0};
      if (v[4]) v = v ^ 5'h13;
    end
    lg[0] = 4'h0;
    gl[0] = 4'h1;
    for (int i = 1; i < 5; i++) gl[i] = 4'h0;
    for (int r = 0; r < 4; r++) begin
      for (int i = 4; i >= 1; i--) gl[i] = gl[i-1] ^ bmul(ex[r], gl[i]);
      gl[0] = bmul(ex[r], gl[0]);
    end
    for (int j = 0; j <= 4; j++) gpoly[j] = gl[4-j];

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(enc_ready && !enc_out_valid && !enc_out_par && !syn_done, "R1 reset",
          int'({enc_ready, enc_out_valid, enc_out_par, syn_done}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    check(enc_ready && !enc_out_valid && !syn_done, "R1 after release",
          int'({enc_ready, enc_out_valid, syn_done}), 4);

    // R2 R3 R5: single nonzero symbol in every position, every value
    for (int p = 0; p < 10; p++)
      for (int val = 1; val < 16; val++) begin
        for (int i = 0; i < 10; i++) msg[i] = (i == p) ? 4'(val) : 4'h0;
        run_enc(0, (val % 2) == 1);
        for (int i = 0; i < 14; i++) rx[i] = cw_dut[i];
        run_syn(0);
        check(syn_zero, "R5 codeword", int'(syn_vec), 0);
      end

    // R4 R9 R8: ramp messages with gaps and junk during the check phase
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 10; i++) msg[i] = 4'((i * k + 3) % 16);
      run_enc(k % 3, 1'b1);
      for (int i = 0; i < 14; i++) rx[i] = cw_dut[i];
      run_syn(k % 3);
      check(syn_zero, "R5 ramp codeword", int'(syn_vec), 0);
    end

    // R6 R7: every single-symbol error on one codeword
    for (int i = 0; i < 10; i++) msg[i] = 4'(9 - i);
    ref_encode();
    for (int p = 0; p < 14; p++)
      for (int e = 1; e < 16; e++) begin
        for (int i = 0; i < 14; i++) rx[i] = cw_ref[i] ^ ((i == p) ? 4'(e) : 4'h0);
        run_syn(p % 2);
        check(!syn_zero, "R7 error seen", int'(syn_zero), 0);
      end

    // R6: arbitrary non-codeword word
    for (int i = 0; i < 14; i++) rx[i] = 4'((i * 7 + 1) % 16);
    run_syn(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule